// File: doc/BRIEF.md
# Segmented Bank Address Translator

This block widens the 16-bit logical address of an 8-bit processor to a 19-bit physical address, giving a 512K physical space. Software programs three 8-bit registers: a window-limit register and two relocation bases. The limit register holds two 4-bit page numbers. They divide the 64K logical space into three windows of 4K granularity: a low fixed window, a middle relocatable window and an upper relocatable window.

For every presented address, the block compares the top logical nibble against the two limits to pick a window. It then forms the upper seven physical bits. In the low window those bits are the nibble zero-extended. In the other two windows they are the nibble plus the window's base, modulo 128. The lower twelve bits pass straight through. The result and a 2-bit window tag appear one clock after the request, or in the same cycle when the `REGISTERED` parameter is 0.

Top module: `seg_xlate`

## Requirements
- R1: After reset, the limit register (select 0) reads F0h and both bases (select 1 for the upper base, select 2 for the middle base) read 00h, so that every logical address L maps to physical address L (zero-extended) before any write.
- R2: A write with `cfg_we`=1 stores `cfg_wdata` into the register chosen by `cfg_sel` (0 limit, 1 upper base, 2 middle base), and all 8 bits read back on `cfg_rdata`. Select 3 reads 00h, and a write to select 3 changes no register.
- R3: When the top logical nibble is greater than or equal to limit bits [7:4], the tag is 2 (upper window) and physical bits [18:12] equal upper base bits [6:0] plus the nibble.
- R4: When the nibble is at least limit bits [3:0] and below limit bits [7:4], the tag is 1 (middle window) and physical bits [18:12] equal middle base bits [6:0] plus the nibble.
- R5: When the nibble is below limit bits [3:0] (and not in the upper window), the tag is 0 (low window) and physical bits [18:12] equal the nibble zero-extended.
- R6: Physical bits [11:0] always equal logical bits [11:0].
- R7: The base-plus-nibble sum wraps modulo 128, so the physical address wraps within 512K.
- R8: When limit bits [7:4] are not above limit bits [3:0], the upper-window test takes priority over the middle-window test.
- R9: With `REGISTERED`=1, `phy_valid`, `phy_addr` and `phy_area` reflect the request presented one clock earlier. A register write in the same cycle as a request takes effect only for later requests.
- R10: Bit 7 of each base register is stored and read back but does not affect translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (0 limit, 1 upper base, 2 middle base, 3 unused) |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Read data of the selected register |
| log_valid | input | 1 | Logical address valid |
| log_addr | input | 16 | Logical address |
| phy_valid | output | 1 | Physical address valid |
| phy_addr | output | 19 | Translated physical address |
| phy_area | output | 2 | Window tag (0 low, 1 middle, 2 upper) |

## Verification
A register write and a translation can occur in the same clock. The write updates the register at the edge that also captures the translation result, so the result must be computed from the value the register held before that edge. The bench provokes this collision by raising `cfg_we` on the upper base while a request aimed at the upper window is presented. It expects the old base in that result and the new base in the request that follows.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    localparam int XL_LOG_W  = 16;
    localparam int XL_PHY_W  = 19;
    localparam int XL_PAGE_W = 4;
    localparam int XL_REG_W  = 8;
    localparam int XL_OFF_W  = XL_LOG_W - XL_PAGE_W;
    localparam int XL_BASE_W = XL_PHY_W - XL_OFF_W;
    localparam int XL_SEL_W  = 2;

    typedef enum logic [1:0] {
        AREA_LOW  = 2'd0,
        AREA_MID  = 2'd1,
        AREA_HIGH = 2'd2
    } area_e;

    typedef struct packed {
        logic [XL_REG_W-1:0] lim;
        logic [XL_REG_W-1:0] hbase;
        logic [XL_REG_W-1:0] mbase;
    } xl_regs_t;

    typedef struct packed {
        logic                valid;
        logic [XL_PHY_W-1:0] addr;
        area_e               area;
    } xl_out_t;

endpackage

// File: rtl/seg_xlate_regs.sv
module seg_xlate_regs
    import seg_xlate_pkg::*;
#(
    parameter logic [XL_REG_W-1:0] RST_LIM = 8'hF0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [XL_SEL_W-1:0]  sel,
    input  logic [XL_REG_W-1:0]  wdata,
    output logic [XL_REG_W-1:0]  rdata,
    output xl_regs_t             regs
);

    xl_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (we) begin
            unique case (sel)
                2'd0:    r_d.lim   = wdata;
                2'd1:    r_d.hbase = wdata;
                2'd2:    r_d.mbase = wdata;
                default: r_d       = r_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.lim   <= RST_LIM;
            r_q.hbase <= '0;
            r_q.mbase <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        unique case (sel)
            2'd0:    rdata = r_q.lim;
            2'd1:    rdata = r_q.hbase;
            2'd2:    rdata = r_q.mbase;
            default: rdata = '0;
        endcase
    end

    assign regs = r_q;

endmodule

// File: rtl/seg_xlate_classify.sv
module seg_xlate_classify
    import seg_xlate_pkg::*;
(
    input  logic [XL_PAGE_W-1:0] page,
    input  logic [XL_REG_W-1:0]  lim,
    output area_e                area
);

    logic [XL_PAGE_W-1:0] hi_lim;
    logic [XL_PAGE_W-1:0] lo_lim;

    assign hi_lim = lim[XL_REG_W-1 -: XL_PAGE_W];
    assign lo_lim = lim[XL_PAGE_W-1:0];

    // Upper window test first: it wins when the limits overlap.
    always_comb begin
        if (page >= hi_lim)      area = AREA_HIGH;
        else if (page >= lo_lim) area = AREA_MID;
        else                     area = AREA_LOW;
    end

endmodule

// File: rtl/seg_xlate_reloc.sv
module seg_xlate_reloc
    import seg_xlate_pkg::*;
(
    input  logic [XL_LOG_W-1:0]  laddr,
    input  area_e                area,
    input  logic [XL_BASE_W-1:0] hbase,
    input  logic [XL_BASE_W-1:0] mbase,
    output logic [XL_PHY_W-1:0]  paddr
);

    logic [XL_PAGE_W-1:0] page;
    logic [XL_BASE_W-1:0] page_x;
    logic [XL_BASE_W-1:0] base_sel;
    logic [XL_BASE_W-1:0] upper;

    assign page   = laddr[XL_LOG_W-1 -: XL_PAGE_W];
    assign page_x = XL_BASE_W'(page);

    always_comb begin
        unique case (area)
            AREA_HIGH: base_sel = hbase;
            AREA_MID:  base_sel = mbase;
            default:   base_sel = '0;
        endcase
        upper = base_sel + page_x;
        paddr = {upper, laddr[XL_OFF_W-1:0]};
    end

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_xlate_pkg::*;
#(
    parameter bit                  REGISTERED = 1'b1,
    parameter logic [XL_REG_W-1:0] RST_LIM    = 8'hF0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [XL_SEL_W-1:0]  cfg_sel,
    input  logic [XL_REG_W-1:0]  cfg_wdata,
    output logic [XL_REG_W-1:0]  cfg_rdata,
    input  logic                 log_valid,
    input  logic [XL_LOG_W-1:0]  log_addr,
    output logic                 phy_valid,
    output logic [XL_PHY_W-1:0]  phy_addr,
    output logic [1:0]           phy_area
);

    xl_regs_t             regs;
    area_e                area_c;
    logic [XL_PHY_W-1:0]  paddr_c;
    logic [XL_REG_W-1:0]  lim_w;
    xl_out_t              out_d;

    seg_xlate_regs #(.RST_LIM(RST_LIM)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .regs  (regs)
    );

    assign lim_w = regs.lim;

    seg_xlate_classify u_cls (
        .page (log_addr[XL_LOG_W-1 -: XL_PAGE_W]),
        .lim  (regs.lim),
        .area (area_c)
    );

    seg_xlate_reloc u_rel (
        .laddr (log_addr),
        .area  (area_c),
        .hbase (regs.hbase[XL_BASE_W-1:0]),
        .mbase (regs.mbase[XL_BASE_W-1:0]),
        .paddr (paddr_c)
    );

    always_comb begin
        out_d.valid = log_valid;
        out_d.addr  = paddr_c;
        out_d.area  = area_c;
    end

    generate
        if (REGISTERED) begin : g_reg
            xl_out_t out_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    out_q.valid <= 1'b0;
                    out_q.addr  <= '0;
                    out_q.area  <= AREA_LOW;
                end else begin
                    out_q <= out_d;
                end
            end
            assign phy_valid = out_q.valid;
            assign phy_addr  = out_q.addr;
            assign phy_area  = out_q.area;
        end else begin : g_comb
            assign phy_valid = out_d.valid;
            assign phy_addr  = out_d.addr;
            assign phy_area  = out_d.area;
        end
    endgenerate

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk
    import seg_xlate_pkg::*;
#(
    parameter bit REGISTERED = 1'b1
) (
    input logic                clk,
    input logic                rst_n,
    input logic                log_valid,
    input logic [XL_LOG_W-1:0] log_addr,
    input logic [XL_REG_W-1:0] lim,
    input logic                phy_valid,
    input logic [XL_PHY_W-1:0] phy_addr,
    input logic [1:0]          phy_area
);

    generate
        if (REGISTERED) begin : g_chk
            p_valid_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
                log_valid |=> phy_valid);

            p_idle_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
                !log_valid |=> !phy_valid);

            p_offset_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
                log_valid |=> (phy_addr[XL_OFF_W-1:0] == $past(log_addr[XL_OFF_W-1:0])));

            p_low_zero_ext_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (log_valid && (log_addr[XL_LOG_W-1 -: XL_PAGE_W] < lim[XL_PAGE_W-1:0]) &&
                 (log_addr[XL_LOG_W-1 -: XL_PAGE_W] < lim[XL_REG_W-1 -: XL_PAGE_W]))
                |=> (phy_area == 2'd0) &&
                    (phy_addr[XL_PHY_W-1:XL_OFF_W] ==
                     XL_BASE_W'($past(log_addr[XL_LOG_W-1 -: XL_PAGE_W]))));

            p_upper_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (log_valid && (log_addr[XL_LOG_W-1 -: XL_PAGE_W] >= lim[XL_REG_W-1 -: XL_PAGE_W]))
                |=> (phy_area == 2'd2));

            p_mid_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (log_valid && (log_addr[XL_LOG_W-1 -: XL_PAGE_W] < lim[XL_REG_W-1 -: XL_PAGE_W]) &&
                 (log_addr[XL_LOG_W-1 -: XL_PAGE_W] >= lim[XL_PAGE_W-1:0]))
                |=> (phy_area == 2'd1));

            p_tag_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
                phy_valid |-> (phy_area != 2'd3));
        end
    endgenerate

endmodule

bind seg_xlate seg_xlate_chk #(.REGISTERED(REGISTERED)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .log_valid (log_valid),
    .log_addr  (log_addr),
    .lim       (lim_w),
    .phy_valid (phy_valid),
    .phy_addr  (phy_addr),
    .phy_area  (phy_area)
);

// File: tb/sim_seg_xlate.sv
`timescale 1ns/1ps
module sim_seg_xlate;

    typedef struct packed {
        logic [7:0]  lim;
        logic [7:0]  hb;
        logic [7:0]  mb;
        logic [15:0] la;
        logic [19:0] pa;
        logic [1:0]  ar;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VT [NV] = '{
        '{8'hF0, 8'h70, 8'h00, 16'hF21A, 20'h7F21A, 2'd2},   // R3
        '{8'hF0, 8'h70, 8'h00, 16'h402C, 20'h0402C, 2'd1},   // R4
        '{8'hF2, 8'h60, 8'h40, 16'h0000, 20'h00000, 2'd0},   // R5
        '{8'hF2, 8'h60, 8'h40, 16'h402C, 20'h4402C, 2'd1},   // R4
        '{8'hF2, 8'h60, 8'h40, 16'hF000, 20'h6F000, 2'd2},   // R3
        '{8'hF2, 8'h60, 8'h40, 16'h1FFF, 20'h01FFF, 2'd0},   // R5 edge
        '{8'hF2, 8'h60, 8'h40, 16'h2000, 20'h42000, 2'd1},   // R4 edge
        '{8'hF2, 8'h60, 8'h40, 16'hEFFF, 20'h4EFFF, 2'd1},   // R4 edge
        '{8'h80, 8'h7F, 8'h00, 16'h9123, 20'h08123, 2'd2},   // R7 wrap
        '{8'h35, 8'h10, 8'h22, 16'h4ABC, 20'h14ABC, 2'd2},   // R8
        '{8'h35, 8'h10, 8'h22, 16'h2ABC, 20'h02ABC, 2'd0},   // R8
        '{8'hF0, 8'h80, 8'h85, 16'hF001, 20'h0F001, 2'd2},   // R10
        '{8'hF0, 8'h80, 8'h85, 16'h1234, 20'h06234, 2'd1},   // R10
        '{8'h48, 8'h00, 8'h30, 16'h7777, 20'h07777, 2'd2}    // R8
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic        log_valid = 1'b0;
    logic [15:0] log_addr = 16'h0;
    logic        phy_valid;
    logic [18:0] phy_addr;
    logic [1:0]  phy_area;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    seg_xlate u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .log_valid(log_valid), .log_addr(log_addr),
        .phy_valid(phy_valid), .phy_addr(phy_addr), .phy_area(phy_area)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, input logic [7:0] exp, input string req);
        @(negedge clk);
        cfg_sel = s;
        #1;
        check(req, 32'(cfg_rdata), 32'(exp));
    endtask

    task automatic xl(input logic [15:0] a, input logic [18:0] exp_pa,
                      input logic [1:0] exp_ar, input string req);
        @(negedge clk);
        log_valid = 1'b1; log_addr = a;
        @(negedge clk);
        log_valid = 1'b0;
        check(req, 32'(phy_valid), 32'd1);
        check(req, 32'(phy_addr), 32'(exp_pa));
        check(req, 32'(phy_area), 32'(exp_ar));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state and identity map
        check("R1 valid", 32'(phy_valid), 32'd0);
        rd(2'd0, 8'hF0, "R1 lim");
        rd(2'd1, 8'h00, "R1 hbase");
        rd(2'd2, 8'h00, "R1 mbase");
        xl(16'h5A5A, 19'h05A5A, 2'd1, "R1 ident");
        xl(16'hFFFF, 19'h0FFFF, 2'd2, "R1 ident");

        // vector table: R3 R4 R5 R6 R7 R8 R10
        for (int i = 0; i < NV; i++) begin
            wr(2'd0, VT[i].lim);
            wr(2'd1, VT[i].hb);
            wr(2'd2, VT[i].mb);
            xl(VT[i].la, VT[i].pa[18:0], VT[i].ar, $sformatf("R3-vec%0d", i));
        end

        // R2: readback of all 8 bits, select 3 ignored
        wr(2'd0, 8'hA7);
        wr(2'd1, 8'hC3);
        wr(2'd2, 8'h9E);
        wr(2'd3, 8'h55);
        rd(2'd0, 8'hA7, "R2 lim");
        rd(2'd1, 8'hC3, "R2 hbase");
        rd(2'd2, 8'h9E, "R2 mbase");
        rd(2'd3, 8'h00, "R2 sel3");

        // R9: same-cycle write uses old base; valid follows
        wr(2'd0, 8'hF0);
        wr(2'd1, 8'h00);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'd1; cfg_wdata = 8'h20;
        log_valid = 1'b1; log_addr = 16'hF100;
        @(negedge clk);
        cfg_we = 1'b0; log_valid = 1'b0;
        check("R9 old", 32'(phy_addr), 32'h0F100);
        check("R9 valid", 32'(phy_valid), 32'd1);
        @(negedge clk);
        check("R9 idle", 32'(phy_valid), 32'd0);
        xl(16'hF100, 19'h2F100, 2'd2, "R9 new");
        xl(16'hF9AB, 19'h2F9AB, 2'd2, "R6 offset");

        $display("test done: total=%0d bad=%0d", total, bad);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule